// File: doc/BRIEF.md
# Parallel Configuration Data Streamer

This block is the master side of a byte-wide passive configuration link. It fetches an image one byte at a time from a synchronous read port with a one-cycle read latency. It drives each byte onto an 8-bit bus together with a data clock that it generates itself, at half the system clock rate. The target samples the bus on the rising edge of that clock. The block changes the bus only together with the falling edge, and it keeps the clock low whenever no byte is being sent.

Two open-drain lines and one input from the target control the transfer. Each open-drain line is modelled as a drive-low enable plus a sampled level. The shared status line holds streaming back until both sides release it, and either side can pull it low to abort. The target's done input ends the image early or on time, after which a programmable number of extra clock cycles is sent so the target can finish its start-up. If the image runs out and done has not arrived, the block flags a failure and holds the status line low. A request input pulses the reconfiguration line low so the target starts over. Pulling the enable input low for one cycle resets the controller.

Top module: `cfg_byte_streamer`

## Requirements
- R1: After reset the block drives the status line low for exactly POR_CYC (default 4) cycles, with the clock low, the bus disabled and the error flag clear. It then releases the line.
- R2: After releasing the status line the block waits, with the clock low and no memory read, until the sampled status line is high. It then reads address 0 and streams from there.
- R3: Bytes leave in ascending address order, one byte per data clock period of two system cycles. Consecutive rising edges are therefore 2 system cycles apart.
- R4: The bus enable is high at every rising edge of the data clock. The data clock stays low whenever the bus enable is low, and the bus value never changes while the clock is high.
- R5: If the status line is low while streaming, the next cycle has the clock low, the bus disabled and the error flag set. No further byte is sent until the line is high again, and the next stream restarts at address 0.
- R6: When done is high at a falling edge, exactly `extra_clks` more rising edges follow. After them the clock stays low and the bus is disabled.
- R7: If the byte at `image_last` has been sent and done is still low at its falling edge, the block sets the error flag, drives the status line low, stops the clock and holds that state.
- R8: A reconfiguration request in the finished, failed or waiting state drives the reconfiguration line low for exactly RC_CYC (default 5) cycles and clears the error flag. The block then returns to waiting.
- R9: A low level on `en_i` at a clock edge resets the controller. At the next cycle the status line is driven low, the bus is disabled, the clock is low and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Output enable; a low level resets the controller |
| image_last | input | AW | Address of the last image byte |
| extra_clks | input | XW | Extra data clock cycles sent after done |
| reconf_req | input | 1 | Request to restart the target's configuration |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| dclk | output | 1 | Generated data clock |
| data_out | output | 8 | Configuration byte to the target |
| data_oe | output | 1 | Bus drive enable |
| stat_in | input | 1 | Sampled level of the status line |
| stat_drive_low | output | 1 | Pulls the status line low |
| done_in | input | 1 | Target reports configuration complete |
| reconf_drive_low | output | 1 | Pulls the reconfiguration line low |
| err_flag | output | 1 | Sticky configuration error |

## Verification
The hardest case to reach is an abort in the middle of a stream. The target must pull the status line low between two byte edges, and the block must then restart cleanly from address 0 with a fresh scoreboard. The bench's target model counts received bytes. When the fifth byte arrives it asserts its own status pull-down, then flushes the expected queue, releases the line and loads a full new image into the queue. The done signal is also raised by the target model from its byte count. This lets the bench run an on-time end, an early end with no extra clocks, and an end with no done at all.

// File: rtl/cfg_byte_streamer.sv
module cfg_byte_streamer #(
  parameter int AW      = 8,
  parameter int XW      = 4,
  parameter int POR_CYC = 4,
  parameter int RC_CYC  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [AW-1:0] image_last,
  input  logic [XW-1:0] extra_clks,
  input  logic          reconf_req,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          dclk,
  output logic [7:0]    data_out,
  output logic          data_oe,
  input  logic          stat_in,
  output logic          stat_drive_low,
  input  logic          done_in,
  output logic          reconf_drive_low,
  output logic          err_flag
);
  localparam int CW = 8;

  typedef enum logic [3:0] {
    S_POR, S_WAIT, S_PRIME, S_LOAD, S_RUN, S_TAIL, S_DONE, S_FAIL, S_RECONF
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic [7:0]    data_q;
  logic          dclk_q;
  logic          err;

  wire at_end = (addr == image_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_POR;
      cnt    <= CW'(POR_CYC - 1);
      addr   <= '0;
      data_q <= '0;
      dclk_q <= 1'b0;
      err    <= 1'b0;
    end else if (!en_i) begin
      st     <= S_POR;
      cnt    <= CW'(POR_CYC - 1);
      addr   <= '0;
      data_q <= '0;
      dclk_q <= 1'b0;
      err    <= 1'b0;
    end else begin
      case (st)
        S_POR: begin
          if (cnt == '0) st <= S_WAIT;
          else cnt <= cnt - 1'b1;
        end
        S_WAIT: begin
          dclk_q <= 1'b0;
          if (reconf_req) begin
            st  <= S_RECONF;
            cnt <= CW'(RC_CYC - 1);
            err <= 1'b0;
          end else if (stat_in) begin
            st <= S_PRIME;
          end
        end
        S_PRIME: begin
          addr <= '0;
          st   <= S_LOAD;
        end
        S_LOAD: begin
          data_q <= mem_rdata;
          dclk_q <= 1'b0;
          st     <= S_RUN;
        end
        S_RUN: begin
          if (!stat_in) begin
            dclk_q <= 1'b0;
            err    <= 1'b1;
            st     <= S_WAIT;
          end else if (!dclk_q) begin
            dclk_q <= 1'b1;
          end else begin
            dclk_q <= 1'b0;
            if (done_in) begin
              st  <= S_TAIL;
              cnt <= CW'(extra_clks);
            end else if (at_end) begin
              err <= 1'b1;
              st  <= S_FAIL;
            end else begin
              addr   <= addr + 1'b1;
              data_q <= mem_rdata;
            end
          end
        end
        S_TAIL: begin
          if (!stat_in) begin
            dclk_q <= 1'b0;
            err    <= 1'b1;
            st     <= S_WAIT;
          end else if (dclk_q) begin
            dclk_q <= 1'b0;
          end else if (cnt == '0) begin
            st <= S_DONE;
          end else begin
            dclk_q <= 1'b1;
            cnt    <= cnt - 1'b1;
          end
        end
        S_DONE, S_FAIL: begin
          if (reconf_req) begin
            st  <= S_RECONF;
            cnt <= CW'(RC_CYC - 1);
            err <= 1'b0;
          end
        end
        S_RECONF: begin
          if (cnt == '0) st <= S_WAIT;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_POR;
      endcase
    end
  end

  assign dclk             = dclk_q;
  assign data_out         = data_q;
  assign data_oe          = (st == S_RUN) || (st == S_TAIL);
  assign stat_drive_low   = (st == S_POR) || (st == S_FAIL);
  assign reconf_drive_low = (st == S_RECONF);
  assign err_flag         = err;
  assign mem_rd           = (st == S_PRIME) ||
                            (st == S_RUN && !dclk_q && stat_in && !at_end);
  assign mem_addr         = (st == S_PRIME) ? '0 : addr + 1'b1;

  p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> $stable(data_out));

  p_clk_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> !dclk);

  p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !stat_in && en_i) |=> (!dclk && !data_oe && err_flag));

  p_end_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && dclk && at_end && !done_in && stat_in && en_i)
      |=> (stat_drive_low && err_flag && !dclk));

  p_reconf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && reconf_req && en_i) |=> (reconf_drive_low && !err_flag));

  p_oe_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (stat_drive_low && !data_oe && !err_flag && !dclk));

  p_read_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
endmodule

// File: tb/test_cfg_byte_streamer.sv
module test_cfg_byte_streamer;
  localparam int AW = 8;
  localparam int XW = 4;
  localparam int N  = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          en_i = 1'b1;
  logic [AW-1:0] image_last = AW'(N - 1);
  logic [XW-1:0] extra_clks = XW'(3);
  logic          reconf_req = 1'b0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = '0;
  logic          dclk;
  logic [7:0]    data_out;
  logic          data_oe;
  logic          stat_drive_low;
  logic          done_in = 1'b0;
  logic          reconf_drive_low;
  logic          err_flag;
  logic          tgt_low = 1'b1;
  wire           stat_in = !(stat_drive_low || tgt_low);

  cfg_byte_streamer #(.AW(AW), .XW(XW), .POR_CYC(4), .RC_CYC(5)) i_cfg_byte_streamer (
    .clk, .rst_n, .en_i, .image_last, .extra_clks, .reconf_req,
    .mem_rd, .mem_addr, .mem_rdata, .dclk, .data_out, .data_oe,
    .stat_in, .stat_drive_low, .done_in, .reconf_drive_low, .err_flag);

  logic [7:0] mem [256];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int checks = 0, fails = 0;
  int cyc = 0, rx = 0, extra = 0, done_at = N, t1 = 0, tl = 0;
  bit auto_done = 1'b1;
  bit dclk_prev = 1'b0;
  logic [7:0] q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_img(input int n);
    for (int i = 0; i < n; i++) q.push_back(mem[i]);
  endtask

  task automatic restart_counts();
    rx = 0; extra = 0; t1 = 0; tl = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (dclk && !dclk_prev) begin
      rx++;
      if (q.size() > 0) begin
        logic [7:0] e;
        e = q.pop_front();
        chk(data_out == e && data_oe, "R3/R4 byte", {data_oe, data_out}, {1'b1, e});
        if (rx == 1) t1 = cyc;
        tl = cyc;
      end else begin
        extra++;
      end
      if (auto_done && rx == done_at) done_in = 1'b1;
    end
    dclk_prev = dclk;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    chk(stat_drive_low && !dclk && !data_oe && !err_flag, "R1 reset state",
        {stat_drive_low, dclk, data_oe, err_flag}, 4'b1000);
    rst_n = 1'b1;
    n = 0;
    while (stat_drive_low && n < 50) begin n++; @(negedge clk); end
    chk(n == 4, "R1 status hold cycles", n, 4);
    repeat (5) @(negedge clk);
    chk(!dclk && !mem_rd && !data_oe, "R2 wait while line low", {dclk, mem_rd, data_oe}, 0);

    // normal image, done on last byte, 3 extra clocks
    restart_counts(); push_img(N); tgt_low = 1'b0;
    repeat (120) @(negedge clk);
    chk(q.size() == 0, "R2 all bytes from address 0", q.size(), 0);
    chk(tl - t1 == 2 * (N - 1), "R3 byte spacing", tl - t1, 2 * (N - 1));
    chk(extra == 3, "R6 extra clocks", extra, 3);
    chk(!dclk && !data_oe && !err_flag, "R6 parked after tail", {dclk, data_oe, err_flag}, 0);

    // reconfiguration request
    reconf_req = 1'b1; @(negedge clk); reconf_req = 1'b0;
    tgt_low = 1'b1; done_in = 1'b0;
    n = 0;
    while (reconf_drive_low && n < 50) begin n++; @(negedge clk); end
    chk(n == 5, "R8 reconf pulse width", n, 5);

    // abort after 5 bytes, then restart from address 0
    restart_counts(); push_img(N);
    repeat (4) @(negedge clk);
    tgt_low = 1'b0;
    n = 0;
    while (rx < 5 && n < 200) begin n++; @(negedge clk); end
    tgt_low = 1'b1;
    @(negedge clk);
    chk(err_flag && !dclk && !data_oe, "R5 abort state", {err_flag, dclk, data_oe}, 3'b100);
    repeat (6) @(negedge clk);
    chk(rx == 5, "R5 no byte while line low", rx, 5);
    q.delete(); restart_counts(); push_img(N); tgt_low = 1'b0;
    repeat (120) @(negedge clk);
    chk(q.size() == 0 && rx == N + 3, "R5 full restart", rx, N + 3);
    chk(err_flag, "R5 error flag kept", err_flag, 1);

    // enable pulse mid-stream, then early done with no extra clocks
    done_in = 1'b0; restart_counts(); push_img(N);
    tgt_low = 1'b1; reconf_req = 1'b1; @(negedge clk); reconf_req = 1'b0;
    repeat (8) @(negedge clk);
    tgt_low = 1'b0;
    n = 0;
    while (rx < 3 && n < 200) begin n++; @(negedge clk); end
    en_i = 1'b0; @(negedge clk); en_i = 1'b1;
    chk(stat_drive_low && !data_oe && !dclk && !err_flag, "R9 enable reset",
        {stat_drive_low, data_oe, dclk, err_flag}, 4'b1000);
    q.delete(); restart_counts(); push_img(8); done_at = 8; extra_clks = '0;
    repeat (100) @(negedge clk);
    chk(q.size() == 0 && rx == 8, "R6 early done byte count", rx, 8);
    chk(extra == 0 && !dclk && !data_oe, "R6 zero extra clocks", extra, 0);

    // no done at all
    auto_done = 1'b0; done_in = 1'b0;
    en_i = 1'b0; @(negedge clk); en_i = 1'b1;
    restart_counts(); push_img(N);
    repeat (120) @(negedge clk);
    chk(q.size() == 0 && rx == N, "R7 whole image sent", rx, N);
    chk(err_flag && stat_drive_low && !dclk && !data_oe, "R7 failure hold",
        {err_flag, stat_drive_low, dclk, data_oe}, 4'b1100);
    reconf_req = 1'b1; @(negedge clk); reconf_req = 1'b0;
    chk(reconf_drive_low && !err_flag && !stat_drive_low, "R8 clears failure",
        {reconf_drive_low, err_flag, stat_drive_low}, 3'b100);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule